// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic unit of a single-cycle 8-bit RISC core. Each cycle it takes a destination operand, a second operand (a register value or an immediate, selected by the caller), an opcode and a bit index. From these it produces a result, a write-back indication and the next value of the status register. The result path is purely combinational. The status register is registered and is written only on cycles where the execute strobe is high.

The status register holds the usual six arithmetic flags (half carry, sign, overflow, negative, zero, carry) plus a user transfer bit T and the global interrupt enable. The carry-in for the carry-using operations comes from the stored carry flag. This lets a sequence of byte operations add, subtract or compare wider numbers. Register file access and instruction decode sit outside the block.

Top module: `byte_alu`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1, carry-in = stored C) return a+b(+C) modulo 256. They set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7 of the result and Z when the result is zero. Status bit positions are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R2: Subtract (op 2), subtract-with-carry (op 3), compare (op 13) and compare-with-carry (op 14) form a-b(-C). C is set to the borrow out of bit 7, H to the borrow out of bit 3, V to signed overflow and N to bit 7. The two compares hold write_back low; the other two raise it.
- R3: For ops 3 and 14, Z becomes 1 only if the result is zero and Z was already 1; in every other case Z is cleared. This lets multi-byte compares chain.
- R4: The logic group (AND op 4, OR op 5, XOR op 6) clears V and keeps H and C. Complement (op 7) returns ~a, sets C and clears V. Clear (op 11) returns 0 with Z=1 and N=V=S=0, keeping H and C. Set-all (op 12) returns 0xFF and changes no flag.
- R5: Negate (op 8) returns 0-a with H, C and V as for a subtraction from zero. Increment (op 9) and decrement (op 10) keep H and C and set V only for the results 0x80 and 0x7F respectively.
- R6: The shift ops each update Z, N, C and set V = N xor C, leaving H unchanged. Left shift (op 15) puts 0 into bit 0 with C = old bit 7. Right shift (op 16) puts 0 into bit 7 with C = old bit 0. Arithmetic right shift (op 19) keeps bit 7 with C = old bit 0.
- R7: Rotate left (op 17) takes the stored C into bit 0 and old bit 7 into C. Rotate right (op 18) takes the stored C into bit 7 and old bit 0 into C. V = N xor C for both.
- R8: Nibble swap (op 20) exchanges bits 7..4 with bits 3..0 and leaves the whole status register unchanged.
- R9: After any op from 0 to 19 other than 12, S equals N xor V.
- R10: Flag set (op 21) sets status bit bit_sel. Flag clear (op 22) clears status bit bit_sel. Neither touches the other bits, and neither writes back.
- R11: Bit store (op 23) copies opd_a[bit_sel] into T without write-back. Bit load (op 24) returns opd_a with bit bit_sel replaced by T and raises write_back.
- R12: The status register resets to 0x00 when rst_n is low. It changes only on rising clock edges where exec is high; while exec is low it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the status register |
| exec | input | 1 | Commit the next status value at the clock edge |
| op | input | 5 | Operation code |
| opd_a | input | 8 | Destination operand |
| opd_b | input | 8 | Second operand, register or immediate |
| bit_sel | input | 3 | Bit index for flag and bit-transfer ops |
| result | output | 8 | Combinational result |
| write_back | output | 1 | Result is to be written to the destination |
| status | output | 8 | Registered status: I,T,H,S,V,N,Z,C from bit 7 to 0 |

## Verification
The hardest situations to reach are the ones that depend on the stored status rather than on the operands. Examples are carry-in for the carry ops, the sticky zero rule of the chained compare, and flags that some ops must keep. The bench loads an exact status value before every vector, using eight single-bit set or clear operations through the normal opcode path. It then applies the operation and compares both the result and the full status byte. Directed sequences then chain a two-byte add and a two-byte compare. In the compare case the low byte differs but the high byte is equal, so a missing Z chain shows up as a wrong zero flag.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   exec,
  input  logic [4:0]             op,
  input  logic [W-1:0]           opd_a,
  input  logic [W-1:0]           opd_b,
  input  logic [$clog2(W)-1:0]   bit_sel,
  output logic [W-1:0]           result,
  output logic                   write_back,
  output logic [7:0]             status
);
  localparam int MSB = W - 1;
  localparam int HW  = W / 2;
  localparam int HB  = HW - 1;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5, FT = 6;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_CLR = 5'd11;
  localparam logic [4:0] OP_SER = 5'd12, OP_CMP = 5'd13, OP_CPC = 5'd14, OP_LSL = 5'd15;
  localparam logic [4:0] OP_LSR = 5'd16, OP_ROL = 5'd17, OP_ROR = 5'd18, OP_ASR = 5'd19;
  localparam logic [4:0] OP_SWP = 5'd20, OP_FST = 5'd21, OP_FCL = 5'd22, OP_BST = 5'd23;
  localparam logic [4:0] OP_BLD = 5'd24;

  logic [7:0]   st, nxt;
  logic [W-1:0] res, sa, sb, sr, dr;
  logic [W:0]   sum, dif;
  logic         wb, ci_add, ci_sub;
  logic         h_add, h_sub, v_add, v_sub;

  assign ci_add = (op == OP_ADC) & st[FC];
  assign ci_sub = ((op == OP_SBC) | (op == OP_CPC)) & st[FC];
  assign sa     = (op == OP_NEG) ? '0 : opd_a;
  assign sb     = (op == OP_NEG) ? opd_a : opd_b;
  assign sum    = {1'b0, opd_a} + {1'b0, opd_b} + {{W{1'b0}}, ci_add};
  assign dif    = {1'b0, sa} - {1'b0, sb} - {{W{1'b0}}, ci_sub};
  assign sr     = sum[W-1:0];
  assign dr     = dif[W-1:0];

  assign h_add = (opd_a[HB] & opd_b[HB]) | (opd_b[HB] & ~sr[HB]) | (~sr[HB] & opd_a[HB]);
  assign h_sub = (~sa[HB] & sb[HB]) | (sb[HB] & dr[HB]) | (dr[HB] & ~sa[HB]);
  assign v_add = (opd_a[MSB] == opd_b[MSB]) && (sr[MSB] != opd_a[MSB]);
  assign v_sub = (sa[MSB] != sb[MSB]) && (dr[MSB] != sa[MSB]);

  always_comb begin
    res = opd_a;
    nxt = st;
    wb  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res = sr; wb = 1'b1;
        nxt[FC] = sum[W]; nxt[FH] = h_add; nxt[FV] = v_add;
        nxt[FN] = sr[MSB]; nxt[FZ] = (sr == '0);
      end
      OP_SUB, OP_CMP, OP_NEG: begin
        res = dr; wb = (op != OP_CMP);
        nxt[FC] = dif[W]; nxt[FH] = h_sub; nxt[FV] = v_sub;
        nxt[FN] = dr[MSB]; nxt[FZ] = (dr == '0);
      end
      OP_SBC, OP_CPC: begin
        res = dr; wb = (op == OP_SBC);
        nxt[FC] = dif[W]; nxt[FH] = h_sub; nxt[FV] = v_sub;
        nxt[FN] = dr[MSB]; nxt[FZ] = (dr == '0) & st[FZ];
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = opd_a & opd_b;
        else if (op == OP_OR) res = opd_a | opd_b;
        else                  res = opd_a ^ opd_b;
        wb = 1'b1;
        nxt[FV] = 1'b0; nxt[FN] = res[MSB]; nxt[FZ] = (res == '0);
      end
      OP_COM: begin
        res = ~opd_a; wb = 1'b1;
        nxt[FC] = 1'b1; nxt[FV] = 1'b0;
        nxt[FN] = res[MSB]; nxt[FZ] = (res == '0);
      end
      OP_INC, OP_DEC: begin
        res = (op == OP_INC) ? opd_a + ONE : opd_a - ONE;
        wb  = 1'b1;
        nxt[FV] = (op == OP_INC) ? (res == MIN_NEG) : (res == MAX_POS);
        nxt[FN] = res[MSB]; nxt[FZ] = (res == '0);
      end
      OP_CLR: begin
        res = '0; wb = 1'b1;
        nxt[FV] = 1'b0; nxt[FN] = 1'b0; nxt[FZ] = 1'b1;
      end
      OP_SER: begin
        res = '1; wb = 1'b1;
      end
      OP_LSL, OP_ROL: begin
        res = {opd_a[W-2:0], (op == OP_ROL) ? st[FC] : 1'b0};
        wb  = 1'b1;
        nxt[FC] = opd_a[MSB]; nxt[FN] = res[MSB]; nxt[FZ] = (res == '0);
        nxt[FV] = res[MSB] ^ opd_a[MSB];
      end
      OP_LSR, OP_ROR, OP_ASR: begin
        if (op == OP_LSR)      res = {1'b0, opd_a[W-1:1]};
        else if (op == OP_ROR) res = {st[FC], opd_a[W-1:1]};
        else                   res = {opd_a[MSB], opd_a[W-1:1]};
        wb = 1'b1;
        nxt[FC] = opd_a[0]; nxt[FN] = res[MSB]; nxt[FZ] = (res == '0);
        nxt[FV] = res[MSB] ^ opd_a[0];
      end
      OP_SWP: begin
        res = {opd_a[HW-1:0], opd_a[W-1:HW]}; wb = 1'b1;
      end
      OP_FST: nxt[bit_sel] = 1'b1;
      OP_FCL: nxt[bit_sel] = 1'b0;
      OP_BST: nxt[FT] = opd_a[bit_sel];
      OP_BLD: begin
        res[bit_sel] = st[FT]; wb = 1'b1;
      end
      default: ;
    endcase
    if (op <= OP_ASR && op != OP_SER)
      nxt[FS] = nxt[FN] ^ nxt[FV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st <= 8'h00;
    else if (exec) st <= nxt;
  end

  assign result     = res;
  assign write_back = wb;
  assign status     = st;

  assert_cmp_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP || op == OP_CPC) |-> !write_back);

  assert_chain_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == OP_SBC || op == OP_CPC) && !status[FZ]) |=> !status[FZ]);

  assert_swap_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_SWP) |=> $stable(status));

  assert_sign_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op <= OP_ASR && op != OP_SER) |=> (status[FS] == (status[FN] ^ status[FV])));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_FST) |=> status[$past(bit_sel)]);

  assert_bit_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_BST) |=> (status[FT] == $past(opd_a[bit_sel])));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(status));
endmodule

// File: tb/byte_alu_bench.sv
`timescale 1ns/1ps
module byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] op = 5'd31;
  logic [7:0] opd_a = '0, opd_b = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result, status;
  logic       write_back;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  byte_alu u_byte_alu (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opd_a(opd_a), .opd_b(opd_b),
    .bit_sel(bit_sel), .result(result), .write_back(write_back), .status(status)
  );

  localparam int NV = 30;
  // {op, a, b, sel, status_in, result, status_out, write_back}
  localparam logic [48:0] VEC [0:NV-1] = '{
    {5'd0,  8'h0F, 8'h01, 3'd0, 8'h00, 8'h10, 8'h20, 1'b1},
    {5'd0,  8'h7F, 8'h01, 3'd0, 8'h00, 8'h80, 8'h2C, 1'b1},
    {5'd1,  8'hFF, 8'h00, 3'd0, 8'h01, 8'h00, 8'h23, 1'b1},
    {5'd2,  8'h10, 8'h01, 3'd0, 8'h00, 8'h0F, 8'h20, 1'b1},
    {5'd2,  8'h00, 8'h01, 3'd0, 8'h00, 8'hFF, 8'h35, 1'b1},
    {5'd2,  8'h80, 8'h01, 3'd0, 8'h00, 8'h7F, 8'h38, 1'b1},
    {5'd3,  8'h05, 8'h05, 3'd0, 8'h02, 8'h00, 8'h02, 1'b1},
    {5'd3,  8'h05, 8'h05, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1},
    {5'd14, 8'h05, 8'h04, 3'd0, 8'h03, 8'h00, 8'h02, 1'b0},
    {5'd13, 8'h01, 8'h02, 3'd0, 8'h00, 8'hFF, 8'h35, 1'b0},
    {5'd4,  8'hF0, 8'h3C, 3'd0, 8'h29, 8'h30, 8'h21, 1'b1},
    {5'd5,  8'h80, 8'h01, 3'd0, 8'h00, 8'h81, 8'h14, 1'b1},
    {5'd6,  8'h5A, 8'h5A, 3'd0, 8'h0C, 8'h00, 8'h02, 1'b1},
    {5'd7,  8'h55, 8'h00, 3'd0, 8'h00, 8'hAA, 8'h15, 1'b1},
    {5'd8,  8'h01, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h35, 1'b1},
    {5'd8,  8'h80, 8'h00, 3'd0, 8'h00, 8'h80, 8'h0D, 1'b1},
    {5'd9,  8'h7F, 8'h00, 3'd0, 8'h21, 8'h80, 8'h2D, 1'b1},
    {5'd10, 8'h80, 8'h00, 3'd0, 8'h00, 8'h7F, 8'h18, 1'b1},
    {5'd10, 8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02, 1'b1},
    {5'd11, 8'h33, 8'h00, 3'd0, 8'h25, 8'h00, 8'h23, 1'b1},
    {5'd12, 8'h00, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h00, 1'b1},
    {5'd15, 8'h81, 8'h00, 3'd0, 8'h00, 8'h02, 8'h19, 1'b1},
    {5'd16, 8'h01, 8'h00, 3'd0, 8'h00, 8'h00, 8'h1B, 1'b1},
    {5'd19, 8'h82, 8'h00, 3'd0, 8'h00, 8'hC1, 8'h0C, 1'b1},
    {5'd17, 8'h80, 8'h00, 3'd0, 8'h01, 8'h01, 8'h19, 1'b1},
    {5'd18, 8'h02, 8'h00, 3'd0, 8'h01, 8'h81, 8'h0C, 1'b1},
    {5'd20, 8'hA5, 8'h00, 3'd0, 8'hFF, 8'h5A, 8'hFF, 1'b1},
    {5'd24, 8'h00, 8'h00, 3'd3, 8'h40, 8'h08, 8'h40, 1'b1},
    {5'd23, 8'h10, 8'h00, 3'd4, 8'h00, 8'h00, 8'h40, 1'b0},
    {5'd23, 8'hEF, 8'h00, 3'd4, 8'hFF, 8'h00, 8'hBF, 1'b0}
  };

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:                      return "R1";
      5'd2, 5'd13:                     return "R2";
      5'd3, 5'd14:                     return "R3";
      5'd4, 5'd5, 5'd6, 5'd7, 5'd11, 5'd12: return "R4";
      5'd8, 5'd9, 5'd10:               return "R5";
      5'd15, 5'd16, 5'd19:             return "R6";
      5'd17, 5'd18:                    return "R7";
      5'd20:                           return "R8";
      5'd21, 5'd22:                    return "R10";
      default:                         return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic load_status(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      op = v[i] ? 5'd21 : 5'd22; bit_sel = 3'(i); exec = 1'b1;
    end
    @(posedge clk); #1;
    exec = 1'b0; op = 5'd31;
  endtask

  task automatic apply(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] s, input logic e);
    @(negedge clk);
    op = o; opd_a = a; opd_b = b; bit_sel = s; exec = e;
    #1;
  endtask

  task automatic commit();
    @(posedge clk); #1;
    exec = 1'b0; op = 5'd31;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    check("R12", "status after reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [48:0] v;
      v = VEC[k];
      load_status(v[24:17]);
      apply(v[48:44], v[43:36], v[35:28], v[27:25], 1'b1);
      if (v[0]) check(req_of(v[48:44]), $sformatf("result vec %0d", k), result, v[16:9]);
      check(req_of(v[48:44]), $sformatf("write_back vec %0d", k), {7'd0, write_back}, {7'd0, v[0]});
      commit();
      check(req_of(v[48:44]), $sformatf("status vec %0d", k), status, v[8:1]);
      if (v[48:44] <= 5'd19 && v[48:44] != 5'd12)
        check("R9", $sformatf("S vs N^V vec %0d", k), {7'd0, status[4]}, {7'd0, status[2] ^ status[3]});
    end

    // R12: no commit while exec is low
    load_status(8'h00);
    apply(5'd0, 8'hFF, 8'h01, 3'd0, 1'b0);
    check("R1", "result with exec low", result, 8'h00);
    commit();
    check("R12", "status held with exec low", status, 8'h00);

    // R10: single-bit set and clear
    apply(5'd21, 8'h00, 8'h00, 3'd7, 1'b1);
    check("R10", "flag set write_back", {7'd0, write_back}, 8'h00);
    commit();
    check("R10", "set bit 7", status, 8'h80);
    load_status(8'hFF);
    apply(5'd22, 8'h00, 8'h00, 3'd2, 1'b1);
    commit();
    check("R10", "clear bit 2", status, 8'hFB);

    // R1: two-byte add 0x01FF + 0x0001
    load_status(8'h00);
    apply(5'd0, 8'hFF, 8'h01, 3'd0, 1'b1);
    check("R1", "low byte sum", result, 8'h00);
    commit();
    check("R1", "low byte flags", status, 8'h23);
    apply(5'd1, 8'h01, 8'h00, 3'd0, 1'b1);
    check("R1", "high byte sum with carry", result, 8'h02);
    commit();
    check("R1", "high byte flags", status, 8'h00);

    // R3: two-byte compare, equal then unequal low byte
    load_status(8'h00);
    apply(5'd13, 8'h34, 8'h34, 3'd0, 1'b1); commit();
    apply(5'd14, 8'h12, 8'h12, 3'd0, 1'b1); commit();
    check("R3", "equal words keep Z", status, 8'h02);
    apply(5'd13, 8'h35, 8'h34, 3'd0, 1'b1); commit();
    apply(5'd14, 8'h12, 8'h12, 3'd0, 1'b1); commit();
    check("R3", "low byte differs, Z stays clear", status, 8'h00);

    // R12: reset in the middle of operation
    load_status(8'hFF);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R12", "status during reset", status, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule